// File: doc/BRIEF.md
# Static Branch Direction Predictor

This block sits in the issue stage and chooses a direction for every branch as the branch is issued. An unconditional branch, or a conditional branch whose condition is already known, is folded: the block gives its true direction in the same cycle, and no speculation is needed. A conditional branch whose condition is still being computed gets a static guess. Backward branches, which have a negative displacement, are guessed taken. Forward branches are guessed not taken. A per-instruction hint bit reverses that guess.

The block keeps track of a single speculated branch at a time. The prediction for that branch is registered. When the pipeline later delivers the real outcome on the resolve strobe, the block compares the two and raises a one-cycle mispredict pulse if they differ. Downstream logic uses that pulse to throw away the speculative results and restart on the correct path. While a speculation is outstanding, a second branch that would need a guess is held with a stall output. Folded branches are never held. Two counters record how many speculations were resolved and how many of them were wrong.

Top module: `branch_dir_pred`

## Requirements
- R1: A valid unconditional branch (`brCond`=0) gives `predTaken`=1, `folded`=1 and `speculative`=0 in the same cycle, whatever `dispNeg`, `hintBit`, `condReady` and `condValue` are.
- R2: A valid conditional branch with `condReady`=1 gives `folded`=1, `speculative`=0 and `predTaken`=`condValue`, and `hintBit` has no effect on it.
- R3: A valid conditional branch with `condReady`=0, `dispNeg`=1 and `hintBit`=0 that is not stalled gives `speculative`=1, `folded`=0 and `predTaken`=1.
- R4: A valid conditional branch with `condReady`=0, `dispNeg`=0 and `hintBit`=0 that is not stalled gives `speculative`=1 and `predTaken`=0.
- R5: For a speculated branch, `hintBit`=1 inverts the displacement-sign guess, so that `predTaken`=`dispNeg` XOR `hintBit`.
- R6: When `brValid`=0, the outputs `predTaken`, `folded`, `speculative` and `stall` are all 0.
- R7: At most one speculated branch is outstanding. A branch that needs a guess while one is outstanding and no resolve arrives in that cycle raises `stall`=1, with `speculative`=0 and `predTaken`=0. Folded branches are never stalled.
- R8: In the cycle after a resolve strobe that arrives with a speculation outstanding, `mispredict` is high for exactly one cycle if `resolveTaken` differs from the registered prediction, and low otherwise. A resolve with nothing outstanding produces no pulse.
- R9: `resolvedCount` increases by one for each resolve that meets an outstanding speculation. `missCount` increases by one for each mispredict, in the same cycle as the pulse. Both counters wrap modulo 2^`CNT_W`.
- R10: After reset, no speculation is outstanding, `mispredict` is 0 and both counters are 0.
- R11: A resolve and a new speculated branch in the same cycle are both accepted. The new branch becomes the outstanding speculation and is not stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| brValid | input | 1 | A branch is at issue this cycle |
| brCond | input | 1 | 1 = conditional, 0 = unconditional |
| dispNeg | input | 1 | Sign of the branch displacement (1 = backward) |
| hintBit | input | 1 | Software hint that inverts the static guess |
| condReady | input | 1 | The tested condition is already evaluated |
| condValue | input | 1 | Evaluated condition (1 = taken) when ready |
| resolveValid | input | 1 | Actual outcome of a branch is delivered |
| resolveTaken | input | 1 | Actual outcome (1 = taken) |
| predTaken | output | 1 | Predicted or folded direction |
| folded | output | 1 | Branch resolved at issue, no speculation |
| speculative | output | 1 | Branch accepted on a guess |
| stall | output | 1 | Speculated branch held off: one already outstanding |
| mispredict | output | 1 | One-cycle pulse: outstanding guess was wrong |
| resolvedCount | output | CNT_W | Number of resolved speculations |
| missCount | output | CNT_W | Number of mispredictions |

## Verification
Some rules are checked by assertions on every clock. These are the folded outcomes for unconditional and ready branches, the exclusion between folded, speculative and stall, the static guess of an accepted speculation, and the rule that a mispredict pulse or a step of the miss counter only ever follows a resolve. Other behaviour needs a history of events and is shown only by the bench's scenarios. That covers stalling a second guess while one is outstanding, the hand-over when a resolve and a new speculation share a cycle, ignoring a resolve that has nothing to match, and counter wrap-around. The bench drives every combination of type, displacement sign, hint, readiness and condition value through a behavioural reference model.

// File: rtl/bdp_pkg.sv
package bdp_pkg;

  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_FOLD = 2'd1,
    CLS_SPEC = 2'd2
  } brClass_e;

  typedef struct packed {
    logic acceptSpec;
    logic resolveHit;
    logic stall;
  } bdpStrobe_t;

endpackage

// File: rtl/bdp_classify.sv
module bdp_classify
  import bdp_pkg::*;
(
  input  logic     brValid,
  input  logic     brCond,
  input  logic     dispNeg,
  input  logic     hintBit,
  input  logic     condReady,
  input  logic     condValue,
  output brClass_e cls,
  output logic     guess
);

  always_comb begin
    if (!brValid)                 cls = CLS_NONE;
    else if (!brCond || condReady) cls = CLS_FOLD;
    else                          cls = CLS_SPEC;
  end

  // Folded branches take the known direction; the hint only steers guesses.
  always_comb begin
    if (!brCond)        guess = 1'b1;
    else if (condReady) guess = condValue;
    else                guess = dispNeg ^ hintBit;
  end

endmodule

// File: rtl/bdp_ctrl.sv
module bdp_ctrl
  import bdp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  brClass_e   cls,
  input  logic       resolveValid,
  output bdpStrobe_t strobe
);

  logic pending;
  logic needSpec;

  assign needSpec          = (cls == CLS_SPEC);
  assign strobe.stall      = needSpec && pending && !resolveValid;
  assign strobe.acceptSpec = needSpec && !strobe.stall;
  assign strobe.resolveHit = resolveValid && pending;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   pending <= 1'b0;
    else if (strobe.acceptSpec)  pending <= 1'b1;
    else if (strobe.resolveHit)  pending <= 1'b0;
  end

endmodule

// File: rtl/bdp_dpath.sv
module bdp_dpath
  import bdp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  brClass_e         cls,
  input  logic             guess,
  input  bdpStrobe_t       strobe,
  input  logic             resolveTaken,
  output logic             predTaken,
  output logic             folded,
  output logic             speculative,
  output logic             mispredict,
  output logic [CNT_W-1:0] resolvedCount,
  output logic [CNT_W-1:0] missCount
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic predReg;
  logic wrongNow;

  assign folded      = (cls == CLS_FOLD);
  assign speculative = strobe.acceptSpec;
  assign predTaken   = (folded || strobe.acceptSpec) ? guess : 1'b0;
  assign wrongNow    = strobe.resolveHit && (resolveTaken != predReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  predReg <= 1'b0;
    else if (strobe.acceptSpec) predReg <= guess;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mispredict    <= 1'b0;
      resolvedCount <= '0;
      missCount     <= '0;
    end else begin
      mispredict <= wrongNow;
      if (strobe.resolveHit) resolvedCount <= resolvedCount + ONE;
      if (wrongNow)          missCount     <= missCount + ONE;
    end
  end

endmodule

// File: rtl/branch_dir_pred.sv
module branch_dir_pred
  import bdp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             brValid,
  input  logic             brCond,
  input  logic             dispNeg,
  input  logic             hintBit,
  input  logic             condReady,
  input  logic             condValue,
  input  logic             resolveValid,
  input  logic             resolveTaken,
  output logic             predTaken,
  output logic             folded,
  output logic             speculative,
  output logic             stall,
  output logic             mispredict,
  output logic [CNT_W-1:0] resolvedCount,
  output logic [CNT_W-1:0] missCount
);

  brClass_e   cls;
  logic       guess;
  bdpStrobe_t strobe;

  bdp_classify classify_i (
    .brValid   (brValid),
    .brCond    (brCond),
    .dispNeg   (dispNeg),
    .hintBit   (hintBit),
    .condReady (condReady),
    .condValue (condValue),
    .cls       (cls),
    .guess     (guess)
  );

  bdp_ctrl ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .cls          (cls),
    .resolveValid (resolveValid),
    .strobe       (strobe)
  );

  bdp_dpath #(.CNT_W(CNT_W)) dpath_i (
    .clk           (clk),
    .rstN          (rstN),
    .cls           (cls),
    .guess         (guess),
    .strobe        (strobe),
    .resolveTaken  (resolveTaken),
    .predTaken     (predTaken),
    .folded        (folded),
    .speculative   (speculative),
    .mispredict    (mispredict),
    .resolvedCount (resolvedCount),
    .missCount     (missCount)
  );

  assign stall = strobe.stall;

endmodule

// File: rtl/bdp_chk.sv
module bdp_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             brValid,
  input logic             brCond,
  input logic             dispNeg,
  input logic             hintBit,
  input logic             condReady,
  input logic             condValue,
  input logic             resolveValid,
  input logic             predTaken,
  input logic             folded,
  input logic             speculative,
  input logic             stall,
  input logic             mispredict,
  input logic [CNT_W-1:0] missCount
);

  // R1
  uncond_fold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (brValid && !brCond) |-> (predTaken && folded && !speculative));

  // R2
  ready_fold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (brValid && brCond && condReady) |-> (folded && !speculative && predTaken == condValue));

  // R5
  spec_guess_chk: assert property (@(posedge clk) disable iff (!rstN)
    speculative |-> (predTaken == (dispNeg ^ hintBit)));

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !brValid |-> !(predTaken || folded || speculative || stall));

  // R7
  excl_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({folded, speculative, stall}));

  // R8
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mispredict) |-> $past(resolveValid));

  // R9
  miss_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(missCount) |-> mispredict);

endmodule

bind branch_dir_pred bdp_chk #(.CNT_W(CNT_W)) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .brValid      (brValid),
  .brCond       (brCond),
  .dispNeg      (dispNeg),
  .hintBit      (hintBit),
  .condReady    (condReady),
  .condValue    (condValue),
  .resolveValid (resolveValid),
  .predTaken    (predTaken),
  .folded       (folded),
  .speculative  (speculative),
  .stall        (stall),
  .mispredict   (mispredict),
  .missCount    (missCount)
);

// File: tb/branch_dir_pred_tb_top.sv
module branch_dir_pred_tb_top;

  localparam int CW   = 4;
  localparam int MASK = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic brValid = 0, brCond = 0, dispNeg = 0, hintBit = 0, condReady = 0, condValue = 0;
  logic resolveValid = 0, resolveTaken = 0;
  logic predTaken, folded, speculative, stall, mispredict;
  logic [CW-1:0] resolvedCount, missCount;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  bit pendRef = 0;
  bit predRef = 0;
  bit mispRef = 0;
  int resRef  = 0;
  int missRef = 0;

  always #2.5 clk = ~clk;

  branch_dir_pred #(.CNT_W(CW)) dut_i (
    .clk(clk), .rstN(rstN), .brValid(brValid), .brCond(brCond), .dispNeg(dispNeg),
    .hintBit(hintBit), .condReady(condReady), .condValue(condValue),
    .resolveValid(resolveValid), .resolveTaken(resolveTaken),
    .predTaken(predTaken), .folded(folded), .speculative(speculative), .stall(stall),
    .mispredict(mispredict), .resolvedCount(resolvedCount), .missCount(missCount)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic checkRegs(input string req);
    chk(mispredict == mispRef, req, "mispredict", int'(mispredict), int'(mispRef));
    chk(int'(resolvedCount) == resRef, "R9", "resolvedCount", int'(resolvedCount), resRef);
    chk(int'(missCount) == missRef, "R9", "missCount", int'(missCount), missRef);
  endtask

  task automatic step(input bit v, input bit c, input bit n, input bit h, input bit r,
                      input bit cv, input bit rv, input bit rt);
    bit specCls, foldE, guessE, stallE, specE, predE, hit;
    string tag;
    @(negedge clk);
    brValid = v; brCond = c; dispNeg = n; hintBit = h; condReady = r; condValue = cv;
    resolveValid = rv; resolveTaken = rt;
    #1;
    specCls = v && c && !r;
    foldE   = v && (!c || r);
    guessE  = !c ? 1'b1 : (r ? cv : (n ^ h));
    stallE  = specCls && pendRef && !rv;
    specE   = specCls && !stallE;
    predE   = (foldE || specE) ? guessE : 1'b0;
    if (!v)                      tag = "R6";
    else if (!c)                 tag = "R1";
    else if (r)                  tag = "R2";
    else if (stallE)             tag = "R7";
    else if (rv && pendRef)      tag = "R11";
    else if (h)                  tag = "R5";
    else if (n)                  tag = "R3";
    else                         tag = "R4";
    chk(predTaken == predE, tag, "predTaken", int'(predTaken), int'(predE));
    chk(folded == foldE, tag, "folded", int'(folded), int'(foldE));
    chk(speculative == specE, tag, "speculative", int'(speculative), int'(specE));
    chk(stall == stallE, tag, "stall", int'(stall), int'(stallE));
    hit     = rv && pendRef;
    mispRef = hit && (rt != predRef);
    if (hit)     resRef  = (resRef + 1) & MASK;
    if (mispRef) missRef = (missRef + 1) & MASK;
    if (specE) begin pendRef = 1; predRef = predE; end
    else if (hit) pendRef = 0;
    @(posedge clk);
    #1;
    checkRegs("R8");
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R10: state after reset
    checkRegs("R10");
    chk(!stall && !speculative, "R10", "flags idle", int'(stall || speculative), 0);

    // Exhaustive sweep; each speculated case resolved next with an outcome mix
    for (int k = 0; k < 32; k++) begin
      step(1, k[0], k[1], k[2], k[3], k[4], 0, 0);
      step(0, 0, 0, 0, 0, 0, 1, k[1]);   // R8 match and mismatch outcomes
    end

    // R7: second guess stalled, folded branch passes while pending
    step(1, 1, 1, 0, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0, 0, 0, 0);
    step(1, 1, 0, 1, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0, 0);
    step(1, 1, 0, 0, 1, 1, 0, 0);
    // R11: resolve plus new guess in the same cycle
    step(1, 1, 0, 1, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 0, 1, 0);
    // R8: resolve with nothing outstanding is ignored
    step(0, 0, 0, 0, 0, 0, 1, 1);
    idle();

    // R9: wrap both counters, every guess wrong
    for (int i = 0; i < 20; i++) begin
      step(1, 1, 1, 0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0, 1, 0);
    end
    idle();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule